// File: doc/BRIEF.md
# Crate Dataway Cycle Sequencer

This block turns one host word or long-word access into a single crate dataway cycle. It decodes the station number, sub-address and function from the access address, raises BUSY, then the first and second strobes, and drives write data for the module. On a read it captures the module's data word and its Q and X responses. When the cycle ends it returns the result to the host with a one-cycle done pulse.

The time from BUSY to the first strobe can be tuned for each station. A 2-bit code per station selects it, and the fastest code also halves the width of both strobes. The codes are packed into three 16-bit tuning registers. The host reads and writes these registers through a reserved local station, and no dataway cycle runs for those accesses. Reads with function 5 use a streaming mode. After each datum with Q present, the sequencer runs the next cycle on its own and parks the result in a one-entry buffer, so the next host read is answered at once.

Top module: `dw_cycle_seq`

## Requirements
- R1: During a dataway cycle the block drives station = address bits 14..10, sub-address = bits 9..6 and function = {write, bits 5..2}. Function bit 16 is 1 for a write and 0 for a read. These values stay steady while BUSY is high.
- R2: The number of 20 ns ticks with BUSY high before the first strobe depends on the station's code: 00 gives 20, 01 gives 15, 10 gives 10 and 11 gives 10. Stations outside 1..24 always use code 00.
- R3: The first and second strobes are each 10 ticks wide, or 5 ticks with code 11. They are separated by a 5-tick gap and are never high together.
- R4: The tuning registers are accessed as local station 30, sub-addresses 0, 1 and 2, covering stations 1–8, 9–16 and 17–24. Station n uses bits 2*((n-1) mod 8)+1 : 2*((n-1) mod 8). Writes take data bits 15..0 and reads return the register in bits 15..0. These accesses produce a done pulse and never raise BUSY.
- R5: Reset returns every tuning code to 00.
- R6: During a write the write-data lines carry data bits 23..0 for a long word, or bits 15..0 zero-extended for a word. They are zero when function bit 8 (address bit 5) is set, during reads, and whenever BUSY is low.
- R7: A long read returns {Q, X, six zeros, data 23..0}. A word read returns {16 zeros, data 15..0}.
- R8: The done pulse lasts one clock and rises one clock after BUSY falls. BUSY is low while done is high.
- R9: A function-5 read that sees Q starts streaming. The block prefetches the next datum into a buffer, and the next function-5 read to the same station and sub-address returns the data in order. Streaming stops once a datum without Q has been returned, and no further strobe cycle follows.
- R10: Any other command issued during streaming runs correctly and discards the prefetched datum. A later function-5 read starts a fresh dataway cycle.
- R11: After reset, done, BUSY, both strobes and the write-data lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz clock, one tick = 20 ns |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle pulse that starts a host access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = long word, 0 = word |
| req_addr | input | 13 | Access address bits 14..2 |
| req_wdata | input | 32 | Host write data |
| done | output | 1 | Access complete pulse |
| rd_data | output | 32 | Result of the access, valid with done |
| dw_busy | output | 1 | Dataway BUSY |
| dw_s1 | output | 1 | First strobe |
| dw_s2 | output | 1 | Second strobe |
| dw_n | output | 5 | Station number |
| dw_a | output | 4 | Sub-address |
| dw_f | output | 5 | Function code |
| dw_w | output | 24 | Write data |
| dw_r | input | 24 | Read data from the module |
| dw_q | input | 1 | Q response |
| dw_x | input | 1 | X response |

## Verification
The hardest case to reach is a host command that arrives while the sequencer is running a prefetch of its own. The block must let that autonomous cycle finish, drop its datum and only then run the new command. The bench reaches this by issuing a non-streaming read immediately after the done pulse of a streaming read, within the cycles before the prefetch completes. It then repeats the sequence after a long idle wait, so the buffer is already full when the interruption comes. A bench model of the module counts strobes and lowers Q after a chosen count, so the order of the returned data shows exactly which datum was lost.

// File: rtl/dw_seq_pkg.sv
package dw_seq_pkg;

    typedef enum logic [2:0] {SG_IDLE, SG_DLY, SG_S1, SG_GAP, SG_S2, SG_REL} sg_state_e;
    typedef enum logic [1:0] {C_IDLE, C_RUN, C_FIN} ctl_state_e;

    typedef struct packed {
        logic        wr;
        logic        lng;
        logic [4:0]  n;
        logic [3:0]  a;
        logic [3:0]  f;
        logic [31:0] wd;
    } cmd_t;

    typedef struct packed {
        logic        q;
        logic        x;
        logic [23:0] r;
    } resp_t;

    localparam logic [3:0] F_STREAM = 4'd5;

    function automatic int imax(int l, int r);
        return (l > r) ? l : r;
    endfunction

    function automatic cmd_t decode(logic wr, logic lng, logic [14:2] addr, logic [31:0] wd);
        cmd_t c;
        c.wr  = wr;
        c.lng = lng;
        c.n   = addr[14:10];
        c.a   = addr[9:6];
        c.f   = addr[5:2];
        c.wd  = wd;
        return c;
    endfunction

    function automatic logic is_stream(cmd_t c);
        return !c.wr && (c.f == F_STREAM);
    endfunction

    function automatic logic [31:0] pack_read(resp_t p, logic lng);
        return lng ? {p.q, p.x, 6'b0, p.r} : {16'b0, p.r[15:0]};
    endfunction

    function automatic logic [23:0] drive_data(cmd_t c);
        if (!c.wr || c.f[3]) return '0;
        return c.lng ? c.wd[23:0] : {8'b0, c.wd[15:0]};
    endfunction

endpackage

// File: rtl/dw_tune_bank.sv
module dw_tune_bank #(
    parameter int N_ST       = 24,
    parameter int ST_PER_REG = 8,
    parameter int REG_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [3:0]       sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    input  logic [4:0]       look_n,
    output logic [1:0]       code
);
    localparam int NREG = N_ST / ST_PER_REG;

    logic [NREG*REG_W-1:0] flat;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                flat[g*REG_W +: REG_W] <= '0;
            else if (we && sel == 4'(g))
                flat[g*REG_W +: REG_W] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++)
            if (sel == 4'(i)) rdata = flat[i*REG_W +: REG_W];
    end

    always_comb begin
        code = 2'b00;
        for (int s = 0; s < N_ST; s++)
            if (look_n == 5'(s + 1)) code = flat[2*s +: 2];
    end

endmodule

// File: rtl/dw_strobe_gen.sv
module dw_strobe_gen
    import dw_seq_pkg::*;
#(
    parameter int DLY0       = 20,
    parameter int DLY1       = 15,
    parameter int DLY2       = 10,
    parameter int STRB       = 10,
    parameter int STRB_SHORT = 5,
    parameter int GAP        = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] code,
    output logic       busy,
    output logic       s1,
    output logic       s2,
    output logic       cap_en,
    output logic       end_p
);
    localparam int MAXT = imax(imax(DLY0, DLY1), imax(imax(DLY2, STRB), GAP));
    localparam int CW   = $clog2(MAXT + 1);

    sg_state_e    st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] wid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SG_IDLE;
            cnt <= '0;
            wid <= '0;
        end else begin
            case (st)
                SG_IDLE: if (start) begin
                    st <= SG_DLY;
                    case (code)
                        2'b00:   cnt <= CW'(DLY0 - 1);
                        2'b01:   cnt <= CW'(DLY1 - 1);
                        default: cnt <= CW'(DLY2 - 1);
                    endcase
                    wid <= (code == 2'b11) ? CW'(STRB_SHORT - 1) : CW'(STRB - 1);
                end
                SG_DLY: if (cnt == '0) begin st <= SG_S1; cnt <= wid; end
                        else cnt <= cnt - 1'b1;
                SG_S1:  if (cnt == '0) begin st <= SG_GAP; cnt <= CW'(GAP - 1); end
                        else cnt <= cnt - 1'b1;
                SG_GAP: if (cnt == '0) begin st <= SG_S2; cnt <= wid; end
                        else cnt <= cnt - 1'b1;
                SG_S2:  if (cnt == '0) st <= SG_REL;
                        else cnt <= cnt - 1'b1;
                default: st <= SG_IDLE;
            endcase
        end
    end

    assign busy   = st inside {SG_DLY, SG_S1, SG_GAP, SG_S2};
    assign s1     = (st == SG_S1);
    assign s2     = (st == SG_S2);
    assign cap_en = (st == SG_S1) && (cnt == '0);
    assign end_p  = (st == SG_REL);

endmodule

// File: rtl/dw_cycle_seq.sv
module dw_cycle_seq
    import dw_seq_pkg::*;
#(
    parameter int         N_ST       = 24,
    parameter int         ST_PER_REG = 8,
    parameter int         REG_W      = 16,
    parameter logic [4:0] LOCAL_N    = 5'd30,
    parameter int         DLY0       = 20,
    parameter int         DLY1       = 15,
    parameter int         DLY2       = 10,
    parameter int         STRB       = 10,
    parameter int         STRB_SHORT = 5,
    parameter int         GAP        = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic        req_long,
    input  logic [14:2] req_addr,
    input  logic [31:0] req_wdata,
    output logic        done,
    output logic [31:0] rd_data,
    output logic        dw_busy,
    output logic        dw_s1,
    output logic        dw_s2,
    output logic [4:0]  dw_n,
    output logic [3:0]  dw_a,
    output logic [4:0]  dw_f,
    output logic [23:0] dw_w,
    input  logic [23:0] dw_r,
    input  logic        dw_q,
    input  logic        dw_x
);
    ctl_state_e ctl;
    cmd_t       in_cmd, pend, cur, scmd;
    resp_t      cap, buff;
    logic       pend_valid, stream_on, pf_want, buf_valid, cur_pf, fin_done;
    logic [31:0] rd_q;

    logic       in_hit, pend_hit, go_buf, go_host, go_local, go_dw, go_pf;
    logic       sg_start, cap_en, end_p;
    logic [4:0] look_n;
    logic [1:0] code;
    logic [REG_W-1:0] tune_rdata;

    assign in_cmd   = decode(req_write, req_long, req_addr, req_wdata);
    assign in_hit   = is_stream(in_cmd) && stream_on && in_cmd.n == scmd.n && in_cmd.a == scmd.a;
    assign pend_hit = is_stream(pend) && stream_on && pend.n == scmd.n && pend.a == scmd.a;

    assign go_buf   = (ctl == C_IDLE) && pend_valid && pend_hit && buf_valid;
    assign go_host  = (ctl == C_IDLE) && pend_valid && !pend_hit;
    assign go_local = go_host && (pend.n == LOCAL_N);
    assign go_dw    = go_host && (pend.n != LOCAL_N);
    assign go_pf    = (ctl == C_IDLE) && !go_buf && !go_host && pf_want;
    assign sg_start = go_dw || go_pf;
    assign look_n   = go_pf ? scmd.n : pend.n;

    dw_tune_bank #(.N_ST(N_ST), .ST_PER_REG(ST_PER_REG), .REG_W(REG_W)) u_tune (
        .clk(clk), .rst(rst),
        .we(go_local && pend.wr), .sel(pend.a), .wdata(pend.wd[REG_W-1:0]),
        .rdata(tune_rdata), .look_n(look_n), .code(code)
    );

    dw_strobe_gen #(.DLY0(DLY0), .DLY1(DLY1), .DLY2(DLY2), .STRB(STRB),
                    .STRB_SHORT(STRB_SHORT), .GAP(GAP)) u_strobe (
        .clk(clk), .rst(rst), .start(sg_start), .code(code),
        .busy(dw_busy), .s1(dw_s1), .s2(dw_s2), .cap_en(cap_en), .end_p(end_p)
    );

    always_ff @(posedge clk) begin
        if (rst) cap <= '0;
        else if (cap_en) cap <= '{q: dw_q, x: dw_x, r: dw_r};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= C_IDLE; pend <= '0; cur <= '0; scmd <= '0; buff <= '0;
            pend_valid <= 1'b0; stream_on <= 1'b0; pf_want <= 1'b0;
            buf_valid <= 1'b0; cur_pf <= 1'b0; fin_done <= 1'b0; rd_q <= '0;
        end else begin
            case (ctl)
                C_IDLE: begin
                    if (go_buf) begin
                        rd_q       <= pack_read(buff, pend.lng);
                        buf_valid  <= 1'b0;
                        pend_valid <= 1'b0;
                        if (buff.q) pf_want <= 1'b1;
                        else        stream_on <= 1'b0;
                        fin_done   <= 1'b1;
                        ctl        <= C_FIN;
                    end else if (go_local) begin
                        rd_q       <= pend.wr ? '0 : {{(32-REG_W){1'b0}}, tune_rdata};
                        pend_valid <= 1'b0;
                        fin_done   <= 1'b1;
                        ctl        <= C_FIN;
                    end else if (go_dw) begin
                        cur        <= pend;
                        cur_pf     <= 1'b0;
                        pend_valid <= 1'b0;
                        ctl        <= C_RUN;
                    end else if (go_pf) begin
                        cur     <= scmd;
                        cur_pf  <= 1'b1;
                        pf_want <= 1'b0;
                        ctl     <= C_RUN;
                    end
                end
                C_RUN: if (end_p) begin
                    ctl <= C_FIN;
                    if (cur_pf) begin
                        buff      <= cap;
                        buf_valid <= stream_on;
                        fin_done  <= 1'b0;
                    end else begin
                        rd_q     <= pack_read(cap, cur.lng);
                        fin_done <= 1'b1;
                        if (is_stream(cur) && cap.q) begin
                            stream_on <= 1'b1;
                            scmd      <= cur;
                            pf_want   <= 1'b1;
                        end
                    end
                end
                default: ctl <= C_IDLE;
            endcase
            if (req_valid) begin
                pend       <= in_cmd;
                pend_valid <= 1'b1;
                if (!in_hit) begin
                    stream_on <= 1'b0;
                    buf_valid <= 1'b0;
                    pf_want   <= 1'b0;
                end
            end
        end
    end

    assign done    = (ctl == C_FIN) && fin_done;
    assign rd_data = rd_q;
    assign dw_n    = dw_busy ? cur.n : '0;
    assign dw_a    = dw_busy ? cur.a : '0;
    assign dw_f    = dw_busy ? {cur.wr, cur.f} : '0;
    assign dw_w    = dw_busy ? drive_data(cur) : '0;

endmodule

// File: rtl/dw_seq_chk.sv
module dw_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        done,
    input logic        dw_busy,
    input logic        dw_s1,
    input logic        dw_s2,
    input logic [4:0]  dw_n,
    input logic [3:0]  dw_a,
    input logic [4:0]  dw_f,
    input logic [23:0] dw_w
);
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(dw_s1 && dw_s2));

    // R2
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (dw_s1 || dw_s2) |-> dw_busy);

    // R2
    busy_before_s1_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dw_s1) |-> $past(dw_busy));

    // R6
    wdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !dw_busy |-> (dw_w == 24'd0));

    // R1
    naf_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (dw_busy && $past(dw_busy)) |-> $stable({dw_n, dw_a, dw_f}));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !dw_busy);

endmodule

bind dw_cycle_seq dw_seq_chk u_chk (
    .clk(clk), .rst(rst), .done(done), .dw_busy(dw_busy), .dw_s1(dw_s1),
    .dw_s2(dw_s2), .dw_n(dw_n), .dw_a(dw_a), .dw_f(dw_f), .dw_w(dw_w)
);

// File: tb/tb_dw_cycle_seq.sv
module tb_dw_cycle_seq;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_long = 1'b0;
    logic [14:2] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        done, dw_busy, dw_s1, dw_s2, dw_q, dw_x;
    logic [31:0] rd_data;
    logic [4:0]  dw_n, dw_f;
    logic [3:0]  dw_a;
    logic [23:0] dw_w, dw_r;

    dw_cycle_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .dw_busy(dw_busy), .dw_s1(dw_s1),
        .dw_s2(dw_s2), .dw_n(dw_n), .dw_a(dw_a), .dw_f(dw_f), .dw_w(dw_w),
        .dw_r(dw_r), .dw_q(dw_q), .dw_x(dw_x)
    );

    always #(CLK_NS/2) clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    logic [23:0] sc = '0;
    int qlim = 0, s1_f5 = 0;
    int m_dly, m_s1w, m_s2w, m_gap, m_busyc, fall_cyc, done_cyc;
    logic m_s1seen, m_s2seen, busy_q = 1'b0, s1_q = 1'b0;
    logic [23:0] m_w;
    logic [13:0] m_nf;
    logic [15:0] tv [3];

    // module model: function 5 streams a counter, others echo the address
    assign dw_r = (dw_f == 5'd5) ? (24'hF00000 | sc) : {3'b0, dw_n, dw_a, 12'h5A5};
    assign dw_q = (dw_f == 5'd5) ? (int'(sc) < qlim) : dw_n[0];
    assign dw_x = (dw_f == 5'd5) ? 1'b1 : !dw_a[0];

    always @(negedge clk) begin
        cyc++;
        if (dw_busy) m_busyc++;
        if (dw_busy && !dw_s1 && !m_s1seen) m_dly++;
        if (dw_s1) begin m_s1w++; m_s1seen = 1'b1; m_w = dw_w; m_nf = {dw_n, dw_a, dw_f}; end
        if (dw_busy && !dw_s1 && !dw_s2 && m_s1seen && !m_s2seen) m_gap++;
        if (dw_s2) begin m_s2w++; m_s2seen = 1'b1; end
        if (dw_s1 && !s1_q && dw_f == 5'd5) s1_f5++;
        if (s1_q && !dw_s1 && dw_f == 5'd5) sc++;
        if (busy_q && !dw_busy) fall_cyc = cyc;
        if (done) done_cyc = cyc;
        busy_q = dw_busy;
        s1_q   = dw_s1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] code_of(input logic [4:0] n);
        if (n >= 5'd1 && n <= 5'd24) return tv[(int'(n) - 1) / 8][2*((int'(n) - 1) % 8) +: 2];
        return 2'b00;
    endfunction

    function automatic int exp_dly(input logic [1:0] c);
        return (c == 2'b00) ? 20 : (c == 2'b01) ? 15 : 10;
    endfunction

    function automatic logic [23:0] exp_w(input logic wr, lng, input logic [3:0] f, input logic [31:0] wd);
        if (!wr || f[3]) return '0;
        return lng ? wd[23:0] : {8'b0, wd[15:0]};
    endfunction

    function automatic logic [31:0] exp_rd(input logic lng, input logic [4:0] n, input logic [3:0] a);
        logic [23:0] r;
        r = {3'b0, n, a, 12'h5A5};
        return lng ? {n[0], !a[0], 6'b0, r} : {16'b0, r[15:0]};
    endfunction

    task automatic host_op(input logic wr, lng, input logic [4:0] n, input logic [3:0] a,
                           input logic [3:0] f, input logic [31:0] wd, output logic [31:0] rd);
        int t;
        @(negedge clk); #1;
        m_dly = 0; m_s1w = 0; m_s2w = 0; m_gap = 0; m_busyc = 0;
        m_s1seen = 1'b0; m_s2seen = 1'b0; fall_cyc = -100; done_cyc = 0;
        req_valid = 1'b1; req_write = wr; req_long = lng;
        req_addr = {n, a, f}; req_wdata = wd;
        @(negedge clk); #1;
        req_valid = 1'b0;
        t = 0;
        while (!done && t < 2000) begin @(negedge clk); #1; t++; end
        if (t >= 2000) chk("R8 done never came", 32'd0, 32'd1);
        rd = rd_data;
    endtask

    task automatic dw_op_check(input logic wr, lng, input logic [4:0] n,
                               input logic [3:0] a, input logic [3:0] f, input logic [31:0] wd);
        logic [31:0] rd;
        logic [1:0]  c;
        host_op(wr, lng, n, a, f, wd, rd);
        c = code_of(n);
        chk("R2 busy-to-s1 ticks", 32'(m_dly), 32'(exp_dly(c)));
        chk("R3 s1 width", 32'(m_s1w), (c == 2'b11) ? 32'd5 : 32'd10);
        chk("R3 s2 width", 32'(m_s2w), (c == 2'b11) ? 32'd5 : 32'd10);
        chk("R3 gap", 32'(m_gap), 32'd5);
        chk("R1 naf", {18'b0, m_nf}, {18'b0, n, a, wr, f});
        chk("R6 write data", {8'b0, m_w}, {8'b0, exp_w(wr, lng, f, wd)});
        chk("R8 done after busy fall", 32'(done_cyc - fall_cyc), 32'd1);
        if (!wr) chk("R7 read format", rd, exp_rd(lng, n, a));
    endtask

    task automatic tune_wr(input int idx, input logic [15:0] v);
        logic [31:0] rd;
        host_op(1'b1, 1'b0, 5'd30, 4'(idx), 4'd0, {16'hDEAD, v}, rd);
        tv[idx] = v;
        chk("R4 local write no busy", 32'(m_busyc), 32'd0);
    endtask

    task automatic tune_rd_chk(input int idx, input string tag);
        logic [31:0] rd;
        host_op(1'b0, 1'b1, 5'd30, 4'(idx), 4'd0, 32'd0, rd);
        chk(tag, rd, {16'b0, tv[idx]});
        chk("R4 local read no busy", 32'(m_busyc), 32'd0);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        bad++; total++;
        $display("FAIL all watchdog expired act=%0d exp=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd4242));
        for (int i = 0; i < 3; i++) tv[i] = '0;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11 done low", {31'b0, done}, 32'd0);
        chk("R11 busy low", {31'b0, dw_busy}, 32'd0);
        chk("R11 strobes low", {30'b0, dw_s1, dw_s2}, 32'd0);
        chk("R11 wdata low", {8'b0, dw_w}, 32'd0);
        #1 rst = 1'b0;

        // R5 codes start at 00
        for (int i = 0; i < 3; i++) tune_rd_chk(i, "R5 tune after reset");
        dw_op_check(1'b0, 1'b1, 5'd4, 4'd1, 4'd0, 32'd0);

        // R2 R3 each code on stations 1..4, plus edges 17 and 24
        tune_wr(0, 16'h00E4);
        tune_wr(2, 16'hC000);
        tune_rd_chk(0, "R4 readback reg0");
        tune_rd_chk(2, "R4 readback reg2");
        for (int s = 1; s <= 4; s++) dw_op_check(1'b0, 1'b1, 5'(s), 4'd2, 4'd1, 32'd0);
        dw_op_check(1'b0, 1'b0, 5'd24, 4'd3, 4'd2, 32'd0);
        dw_op_check(1'b0, 1'b1, 5'd17, 4'd0, 4'd0, 32'd0);
        dw_op_check(1'b0, 1'b1, 5'd31, 4'd5, 4'd3, 32'd0);

        // R6 write data and function-bit-8 suppression
        dw_op_check(1'b1, 1'b1, 5'd9, 4'd1, 4'd0, 32'hABCD_1234);
        dw_op_check(1'b1, 1'b0, 5'd9, 4'd1, 4'd1, 32'hABCD_1234);
        dw_op_check(1'b1, 1'b1, 5'd9, 4'd1, 4'd8, 32'hFFFF_FFFF);

        // random tuning and accesses
        for (int i = 0; i < 3; i++) tune_wr(i, 16'($urandom));
        for (int i = 0; i < 3; i++) tune_rd_chk(i, "R4 random readback");
        for (int k = 0; k < 40; k++) begin
            logic [4:0] n; logic [3:0] f; logic wr;
            n  = 5'($urandom_range(0, 31));
            if (n == 5'd30) n = 5'd12;
            wr = 1'($urandom);
            f  = 4'($urandom);
            if (!wr && f == 4'd5) f = 4'd6;
            dw_op_check(wr, 1'($urandom), n, 4'($urandom), f, $urandom);
        end

        // R5 reset clears tuning
        tune_wr(0, 16'hFFFF);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 3; i++) tv[i] = '0;
        tune_rd_chk(0, "R5 reg0 cleared");
        dw_op_check(1'b0, 1'b1, 5'd4, 4'd0, 4'd0, 32'd0);

        // R9 streaming with Q lost after three data
        idle(2); #1; sc = '0; qlim = 3; s1_f5 = 0;
        for (int k = 0; k < 5; k++) begin
            host_op(1'b0, 1'b1, 5'd5, 4'd2, 4'd5, 32'd0, rd);
            chk("R9 stream datum", rd, {(k < 3), 1'b1, 6'b0, 24'hF00000 | 24'(k)});
            idle(40);
        end
        idle(100);
        chk("R9 strobe count after Q lost", 32'(s1_f5), 32'd5);

        // R10 other command right after a stream read, prefetch in flight
        idle(2); #1; sc = '0; qlim = 100; s1_f5 = 0;
        host_op(1'b0, 1'b1, 5'd5, 4'd2, 4'd5, 32'd0, rd);
        chk("R10 first stream datum", rd, {2'b11, 6'b0, 24'hF00000});
        host_op(1'b0, 1'b1, 5'd3, 4'd1, 4'd0, 32'd0, rd);
        chk("R10 interleaved read", rd, exp_rd(1'b1, 5'd3, 4'd1));
        host_op(1'b0, 1'b1, 5'd5, 4'd2, 4'd5, 32'd0, rd);
        chk("R10 prefetch discarded", rd, {2'b11, 6'b0, 24'hF00002});
        idle(60);
        host_op(1'b1, 1'b0, 5'd3, 4'd0, 4'd0, 32'd7, rd);
        idle(100);
        chk("R10 strobes stop after other command", 32'(s1_f5), 32'd4);

        // R10 other command after the buffer is already full
        idle(2); #1; sc = '0; s1_f5 = 0;
        host_op(1'b0, 1'b0, 5'd5, 4'd2, 4'd5, 32'd0, rd);
        chk("R10 word stream datum", rd, {16'b0, 16'h0000});
        idle(80);
        host_op(1'b1, 1'b1, 5'd6, 4'd4, 4'd2, 32'h0012_3456, rd);
        chk("R10 write during stream data", {8'b0, m_w}, 32'h0012_3456);
        host_op(1'b0, 1'b1, 5'd5, 4'd2, 4'd5, 32'd0, rd);
        chk("R10 fresh cycle after discard", rd, {2'b11, 6'b0, 24'hF00002});
        host_op(1'b0, 1'b1, 5'd7, 4'd0, 4'd0, 32'd0, rd);
        chk("R10 stop read", rd, exp_rd(1'b1, 5'd7, 4'd0));

        idle(20);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule